// File: doc/BRIEF.md
# Three-Phase PWM Generator with Constant Shoot-Through Band

This block drives the six gate signals of a three-phase impedance-source inverter bridge. An internal signed triangular carrier counts up and down between a positive and a negative peak. Every clock, each phase reference is compared with the carrier to produce a complementary pair of gate levels, one for the upper switch and one for the lower switch.

Two signed threshold levels define a constant shoot-through band. When the carrier lies above the upper level or below the lower level, both switches of every leg are turned on together. This boosts the link voltage while leaving the active vectors unchanged. The threshold levels are adopted only at a carrier turning point, so a carrier period is never split between two settings.

All comparator inputs are registered, and every gate output leaves through a flip-flop, which gives a fixed two-clock latency. A sine source upstream supplies the references. For the intended duty limit, it keeps the upper level at or above the reference peak and the lower level at or below the negative peak.

Top module: `zsrc_boost_pwm`

## Requirements
- R1: The carrier leaves reset at 0 counting upward. It changes by exactly one on every clock with `en` high. On reaching +PEAK (default 300) it reverses and counts down; on reaching −PEAK it reverses and counts up. Its period is therefore 4·PEAK enabled clocks, and it never leaves [−PEAK, +PEAK].
- R2: With `en` low, the carrier and its direction hold their values. The compare path keeps running on the held carrier value.
- R3: While the synchronous active-high `rst` is high, all six gate outputs are 0 and the carrier reads 0.
- R4: Outside shoot-through, in each leg the upper gate is 1 and the lower gate is 0 when the reference is strictly greater than the carrier. Otherwise the upper gate is 0 and the lower gate is 1. Equality therefore gives upper 0, lower 1.
- R5: When the carrier is strictly greater than the adopted upper level, or strictly less than the adopted lower level, all six gate outputs are 1. A carrier equal to either level is not in shoot-through.
- R6: `lvl_hi` and `lvl_lo` are adopted while `rst` is high and on any clock at which the carrier equals +PEAK or −PEAK. The adopted levels then apply from that carrier sample onward. Values presented at any other time have no effect.
- R7: A set of references sampled at a rising edge, together with the carrier value held just before that edge and the level adopted at it, determines the gate outputs after the next rising edge. This is a latency of two clocks from input to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Carrier step enable |
| ref_a | input | W | Signed reference, phase A |
| ref_b | input | W | Signed reference, phase B |
| ref_c | input | W | Signed reference, phase C |
| lvl_hi | input | W | Signed upper shoot-through level |
| lvl_lo | input | W | Signed lower shoot-through level |
| carrier | output | W | Signed triangular carrier value |
| a_hi | output | 1 | Phase A upper gate |
| a_lo | output | 1 | Phase A lower gate |
| b_hi | output | 1 | Phase B upper gate |
| b_lo | output | 1 | Phase B lower gate |
| c_hi | output | 1 | Phase C upper gate |
| c_lo | output | 1 | Phase C lower gate |

## Verification
The stimulus uses four patterns:

- **Three-phase sines at 220 counts with levels at ±PEAK.** Shoot-through never occurs, so this isolates the complementary compare and the two-clock alignment.
- **The same sines with a ±250 band and a gappy enable.** This separates the shoot-through override from the compare and checks that held carrier samples still pass through the compare.
- **References pinned to the carrier value and to one count on either side, while the levels change every clock.** This exposes strict-versus-inclusive compare errors and any adoption of a level away from a turning point.
- **A mid-run reset followed by a zero-width band.** This checks the reset state and shows that only a carrier of exactly 0 escapes shoot-through.

// File: rtl/zsrc_boost_pwm.sv
module zsrc_boost_pwm #(
  parameter int W    = 12,
  parameter int PEAK = 300
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] ref_a,
  input  logic signed [W-1:0] ref_b,
  input  logic signed [W-1:0] ref_c,
  input  logic signed [W-1:0] lvl_hi,
  input  logic signed [W-1:0] lvl_lo,
  output logic signed [W-1:0] carrier,
  output logic                a_hi,
  output logic                a_lo,
  output logic                b_hi,
  output logic                b_lo,
  output logic                c_hi,
  output logic                c_lo
);
  localparam int LEGS = 3;
  localparam logic signed [W-1:0] TOP = W'(PEAK);
  localparam logic signed [W-1:0] BOT = W'(-PEAK);
  localparam logic signed [W-1:0] ONE = W'(1);

  logic signed [W-1:0] car, car_q, th_hi, th_lo;
  logic                going_dn;
  logic signed [W-1:0] ref_in [LEGS];
  logic signed [W-1:0] ref_q  [LEGS];
  logic [LEGS-1:0]     g_hi, g_lo;
  logic                at_turn, shoot;

  assign ref_in[0] = ref_a;
  assign ref_in[1] = ref_b;
  assign ref_in[2] = ref_c;
  assign at_turn   = (car == TOP) || (car == BOT);
  assign shoot     = (car_q > th_hi) || (car_q < th_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      car      <= '0;
      going_dn <= 1'b0;
    end else if (en) begin
      if (!going_dn) begin
        car <= car + ONE;
        if (car == TOP - ONE) going_dn <= 1'b1;
      end else begin
        car <= car - ONE;
        if (car == BOT + ONE) going_dn <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    car_q <= car;
    if (rst || at_turn) begin
      th_hi <= lvl_hi;
      th_lo <= lvl_lo;
    end
  end

  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    logic above;
    assign above = ref_q[i] > car_q;
    always_ff @(posedge clk) begin
      ref_q[i] <= ref_in[i];
      if (rst) begin
        g_hi[i] <= 1'b0;
        g_lo[i] <= 1'b0;
      end else begin
        g_hi[i] <= shoot | above;
        g_lo[i] <= shoot | ~above;
      end
    end
  end

  assign carrier = car;
  assign a_hi = g_hi[0];
  assign a_lo = g_lo[0];
  assign b_hi = g_hi[1];
  assign b_lo = g_lo[1];
  assign c_hi = g_hi[2];
  assign c_lo = g_lo[2];
endmodule

// File: rtl/zsrc_boost_pwm_chk.sv
module zsrc_boost_pwm_chk #(
  parameter int W    = 12,
  parameter int PEAK = 300
) (
  input logic                clk,
  input logic                rst,
  input logic                en,
  input logic signed [W-1:0] car,
  input logic signed [W-1:0] th_hi,
  input logic signed [W-1:0] th_lo,
  input logic [2:0]          gh,
  input logic [2:0]          gl
);
  localparam logic signed [W-1:0] TOP = W'(PEAK);
  localparam logic signed [W-1:0] BOT = W'(-PEAK);
  localparam logic signed [W-1:0] ONE = W'(1);

  a_r1_range: assert property (@(posedge clk) disable iff (rst)
    (car <= TOP) && (car >= BOT));

  a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
    en |=> ((car == $past(car) + ONE) || (car == $past(car) - ONE)));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(car));

  a_r3_clear: assert property (@(posedge clk)
    rst |=> (gh == 3'b000 && gl == 3'b000 && car == '0));

  a_r4_pairs: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((gh & gl) == 3'b111) || ((gh ^ gl) == 3'b111)));

  a_r5_all_legs: assert property (@(posedge clk) disable iff (rst)
    (|(gh & gl)) |-> ($countones(gh & gl) == 3));

  a_r6_level_hold: assert property (@(posedge clk) disable iff (rst)
    (car != TOP && car != BOT) |=> ($stable(th_hi) && $stable(th_lo)));
endmodule

bind zsrc_boost_pwm zsrc_boost_pwm_chk #(.W(W), .PEAK(PEAK)) u_chk (
  .clk(clk), .rst(rst), .en(en), .car(car),
  .th_hi(th_hi), .th_lo(th_lo), .gh(g_hi), .gl(g_lo)
);

// File: tb/zsrc_boost_pwm_bench.sv
module zsrc_boost_pwm_bench;
  localparam int W = 12;
  localparam int PEAK = 300;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic signed [W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic signed [W-1:0] lvl_hi = W'(PEAK), lvl_lo = W'(-PEAK);
  logic signed [W-1:0] carrier;
  logic a_hi, a_lo, b_hi, b_lo, c_hi, c_lo;

  zsrc_boost_pwm #(.W(W), .PEAK(PEAK)) u_zsrc_boost_pwm (
    .clk(clk), .rst(rst), .en(en),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .carrier(carrier),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo), .c_hi(c_hi), .c_lo(c_lo)
  );

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int mc = 0;
  bit mdn = 1'b0;
  int tp = PEAK, tn = -PEAK;
  bit prev_en = 1'b1;
  logic [5:0] pipe_exp [2];
  bit pipe_v [2];
  string pipe_tag [2];

  function automatic logic [5:0] gates();
    return {c_lo, c_hi, b_lo, b_hi, a_lo, a_hi};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int lh, input int ll);
    @(negedge clk);
    rst = 1'b1;
    en = 1'b1;
    lvl_hi = W'(lh);
    lvl_lo = W'(ll);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(gates() == 6'b0, "R3 gates", int'(gates()), 0);
      check(carrier == 0, "R3 carrier", int'(carrier), 0);
    end
    rst = 1'b0;
    tp = lh;
    tn = ll;
    mc = 1;
    mdn = 1'b0;
    prev_en = 1'b1;
    pipe_v[0] = 1'b0;
    pipe_v[1] = 1'b0;
  endtask

  task automatic step(input bit e, input int ra, input int rb, input int rc,
                      input int lh, input int ll, input string tag);
    int r [3];
    bit st, ab;
    logic [5:0] ex;
    @(negedge clk);
    check(carrier == mc, prev_en ? "R1 carrier" : "R2 carrier", int'(carrier), mc);
    if (pipe_v[1]) check(gates() == pipe_exp[1], pipe_tag[1], int'(gates()), int'(pipe_exp[1]));
    pipe_exp[1] = pipe_exp[0];
    pipe_v[1] = pipe_v[0];
    pipe_tag[1] = pipe_tag[0];
    en = e;
    ref_a = W'(ra);
    ref_b = W'(rb);
    ref_c = W'(rc);
    lvl_hi = W'(lh);
    lvl_lo = W'(ll);
    if (mc == PEAK || mc == -PEAK) begin
      tp = lh;
      tn = ll;
    end
    r[0] = ra; r[1] = rb; r[2] = rc;
    st = (mc > tp) || (mc < tn);
    for (int i = 0; i < 3; i++) begin
      ab = r[i] > mc;
      ex[2*i]   = st | ab;
      ex[2*i+1] = st | ~ab;
    end
    pipe_exp[0] = ex;
    pipe_v[0] = 1'b1;
    pipe_tag[0] = tag;
    if (e) begin
      if (!mdn) begin
        mc++;
        if (mc == PEAK) mdn = 1'b1;
      end else begin
        mc--;
        if (mc == -PEAK) mdn = 1'b0;
      end
    end
    prev_en = e;
  endtask

  function automatic int sine(input int k, input real ph);
    return $rtoi(220.0 * $sin(TWO_PI * real'(k) / real'(4 * PEAK) + ph));
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(PEAK, -PEAK);
    // R4 R7: sines, band outside carrier range, no shoot-through
    for (int k = 0; k < 2500; k++)
      step(1'b1, sine(k, 0.0), sine(k, TWO_PI / 3.0), sine(k, -TWO_PI / 3.0),
           PEAK, -PEAK, "R4 R7 sine compare");
    // R5 R6 R2: narrower band adopted at next turning point, gappy enable
    for (int k = 0; k < 2500; k++)
      step(k % 5 != 2, sine(k, 0.0), sine(k, TWO_PI / 3.0), sine(k, -TWO_PI / 3.0),
           250, -250, "R5 R6 band");
    // R4 R6: references at and beside the carrier, levels churning every clock
    for (int k = 0; k < 2500; k++) begin
      int lh;
      lh = 100 + (k * 37) % 200;
      step(1'b1, mc, mc + 1, mc - 1, lh, -lh, "R4 R6 edge compare");
    end
    // R3 R5: reset mid-run, then a zero-width band
    do_reset(0, 0);
    for (int k = 0; k < 1300; k++)
      step(1'b1, sine(k, 0.0), sine(k, TWO_PI / 3.0), sine(k, -TWO_PI / 3.0),
           0, 0, "R5 zero band");
    repeat (2) step(1'b1, 0, 0, 0, 0, 0, "R5 drain");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule